// File: doc/BRIEF.md
# Snooping Coherent Bus Router

This block joins several cache-side ports to one memory-side port and keeps them coherent by forwarding snoops. A request from a cache is sent to memory tagged with the requester's port id. If the request is cacheable, the same message is also presented as a snoop to every other cache. Memory replies are steered back by that id. Snoops that start on the memory side are sent to every cache. A cache answers a snoop with a snoop reply that names its destination. The destination is either a cache port id or the memory id, and the reply is delivered there.

Memory and peers see one shared message per cacheable request. A cache that will supply the data raises its inhibit input while the snoop is presented. The router then marks the memory request as inhibited, and memory must drop it. The requester therefore gets exactly one answer. After each transfer that reaches a cache, and after each snoop reply handed to memory, the router refuses new work for a configurable number of cycles. During that interval it lowers ready on cache requests, memory replies and memory snoops. Snoop replies are never refused by this interval.

All outputs are registered, so a message appears one cycle after it is accepted. The memory id is the value NPORT.

Top module: `snoop_bus_router`

## Requirements
- R1: After reset no output valid is asserted, and the ready outputs for cache requests, memory replies and memory snoops are not held low by a busy interval.
- R2: A cache request accepted on port i appears on the memory-side request one cycle later, with source id i, the same tag and the same cacheable flag.
- R3: A cacheable request is also presented one cycle after acceptance as a snoop to every cache port except the requester, with source id i and the request tag. An uncacheable request produces no snoop.
- R4: A memory reply accepted with destination d (d < NPORT) appears one cycle later as a reply on cache port d with the same tag, and its peer flag is low.
- R5: A memory snoop is presented one cycle after acceptance to all cache ports with source id NPORT. In a cycle where a memory snoop is offered, no cache request is accepted.
- R6: An accepted snoop reply with destination NPORT appears one cycle later on the memory-side snoop-reply output. With destination d < NPORT it appears on cache reply port d with the peer flag high.
- R7: Accepting a cacheable request, a memory reply, a memory snoop or a snoop reply lowers the cache-request, memory-reply and memory-snoop readies for exactly BLOCK_CYC cycles, counted from the next cycle. A later such event restarts the count. An uncacheable request starts no interval.
- R8: Snoop replies are accepted during a busy interval.
- R9: The memory request's inhibit output is high only when the request is cacheable and at least one port receiving its snoop raises inhibit in that same cycle. The requester's own inhibit input is ignored.
- R10: At most one cache request is accepted per cycle, chosen round robin. After port g wins, port g+1 (modulo NPORT) has the highest priority.
- R11: At most one snoop reply is accepted per cycle, chosen round robin in the same way as R10.
- R12: A memory reply is refused in a cycle where the accepted snoop reply targets the same cache port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_req_valid | input | NPORT | Request offered by each cache port |
| c_req_ready | output | NPORT | Request accepted on that port |
| c_req_cacheable | input | NPORT | Request targets cacheable memory |
| c_req_tag | input | NPORT*TAG_W | Request tag per port |
| c_snp_valid | output | NPORT | Snoop presented to each cache port |
| c_snp_src | output | IDW | Originator id of the snoop (NPORT = memory) |
| c_snp_tag | output | TAG_W | Snoop tag |
| c_snp_inhibit | input | NPORT | Cache will answer the snoop presented this cycle |
| c_srsp_valid | input | NPORT | Snoop reply offered by each cache port |
| c_srsp_ready | output | NPORT | Snoop reply accepted on that port |
| c_srsp_dst | input | NPORT*IDW | Destination id per snoop reply |
| c_srsp_tag | input | NPORT*TAG_W | Snoop reply tag per port |
| c_rsp_valid | output | NPORT | Reply delivered to each cache port |
| c_rsp_tag | output | NPORT*TAG_W | Reply tag per port |
| c_rsp_from_peer | output | NPORT | Reply came from a peer cache, not memory |
| m_req_valid | output | 1 | Request to memory |
| m_req_src | output | IDW | Requesting port id |
| m_req_tag | output | TAG_W | Request tag |
| m_req_cacheable | output | 1 | Request is cacheable |
| m_req_inhibit | output | 1 | A peer will answer; memory must drop the request |
| m_rsp_valid | input | 1 | Memory reply offered |
| m_rsp_ready | output | 1 | Memory reply accepted |
| m_rsp_dst | input | IDW | Destination port of the memory reply |
| m_rsp_tag | input | TAG_W | Memory reply tag |
| m_snp_valid | input | 1 | Snoop offered by the memory side |
| m_snp_ready | output | 1 | Memory snoop accepted |
| m_snp_tag | input | TAG_W | Memory snoop tag |
| m_srsp_valid | output | 1 | Snoop reply delivered to the memory side |
| m_srsp_tag | output | TAG_W | Tag of that snoop reply |

## Verification
The properties assume that a memory reply's destination is below NPORT and that a snoop reply's destination is at most NPORT. They also assume that inputs are zero during reset. Nothing else is assumed about the inputs. Valids may rise, fall or change their fields in any cycle, because the router samples only in the cycle of acceptance. The random stimulus draws destinations modulo the legal range and sets every input each cycle. It mixes in directed cases for snoop/request collisions, reply collisions on one port, and inhibit from the requester versus a peer.

// File: rtl/snoop_bus_pkg.sv
package snoop_bus_pkg;

    // Transfers that start a busy interval, one flag per kind.
    typedef struct packed {
        logic req_snoop;   // cacheable request fanned out as snoops
        logic mem_reply;   // memory reply delivered to a cache
        logic mem_snoop;   // memory snoop broadcast to caches
        logic peer_reply;  // snoop reply passed cache to cache
        logic home_reply;  // snoop reply handed to memory
    } blk_evt_t;

endpackage

// File: rtl/snoop_bus_rr.sv
module snoop_bus_rr #(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] idx
);

    logic [IW-1:0] ptr_d, ptr_q;

    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (!any && req[j]) begin
                any      = 1'b1;
                grant[j] = 1'b1;
                idx      = IW'(j);
            end
        end
        ptr_d = ptr_q;
        if (advance && any) begin
            ptr_d = (int'(idx) == N - 1) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/snoop_bus_block_timer.sv
module snoop_bus_block_timer
    import snoop_bus_pkg::*;
#(
    parameter int BLOCK_CYC = 3,
    parameter int CW        = $clog2(BLOCK_CYC + 2)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  blk_evt_t evt,
    output logic     blocked
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          hit;

    always_comb begin
        hit = |evt;
        if (hit)                cnt_d = CW'(BLOCK_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
        blocked = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/snoop_bus_router.sv
module snoop_bus_router
    import snoop_bus_pkg::*;
#(
    parameter int NPORT     = 3,
    parameter int TAG_W     = 8,
    parameter int BLOCK_CYC = 3,
    localparam int IDW      = $clog2(NPORT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       c_req_valid,
    output logic [NPORT-1:0]       c_req_ready,
    input  logic [NPORT-1:0]       c_req_cacheable,
    input  logic [NPORT*TAG_W-1:0] c_req_tag,
    output logic [NPORT-1:0]       c_snp_valid,
    output logic [IDW-1:0]         c_snp_src,
    output logic [TAG_W-1:0]       c_snp_tag,
    input  logic [NPORT-1:0]       c_snp_inhibit,
    input  logic [NPORT-1:0]       c_srsp_valid,
    output logic [NPORT-1:0]       c_srsp_ready,
    input  logic [NPORT*IDW-1:0]   c_srsp_dst,
    input  logic [NPORT*TAG_W-1:0] c_srsp_tag,
    output logic [NPORT-1:0]       c_rsp_valid,
    output logic [NPORT*TAG_W-1:0] c_rsp_tag,
    output logic [NPORT-1:0]       c_rsp_from_peer,
    output logic                   m_req_valid,
    output logic [IDW-1:0]         m_req_src,
    output logic [TAG_W-1:0]       m_req_tag,
    output logic                   m_req_cacheable,
    output logic                   m_req_inhibit,
    input  logic                   m_rsp_valid,
    output logic                   m_rsp_ready,
    input  logic [IDW-1:0]         m_rsp_dst,
    input  logic [TAG_W-1:0]       m_rsp_tag,
    input  logic                   m_snp_valid,
    output logic                   m_snp_ready,
    input  logic [TAG_W-1:0]       m_snp_tag,
    output logic                   m_srsp_valid,
    output logic [TAG_W-1:0]       m_srsp_tag
);

    localparam int PW                = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam logic [IDW-1:0] MEM_ID = IDW'(NPORT);

    typedef struct packed {
        logic                   req_v;
        logic [IDW-1:0]         req_src;
        logic [TAG_W-1:0]       req_tag;
        logic                   req_cach;
        logic [NPORT-1:0]       snp_v;
        logic [IDW-1:0]         snp_src;
        logic [TAG_W-1:0]       snp_tag;
        logic [NPORT-1:0]       rsp_v;
        logic [NPORT*TAG_W-1:0] rsp_tag;
        logic [NPORT-1:0]       rsp_peer;
        logic                   hrsp_v;
        logic [TAG_W-1:0]       hrsp_tag;
    } state_t;

    state_t st_d, st_q;

    logic             blocked;
    blk_evt_t         evt;

    logic [NPORT-1:0] rq_grant;
    logic             rq_any;
    logic [PW-1:0]    rq_idx;
    logic             rq_fire;

    logic [NPORT-1:0] sr_grant;
    logic             sr_any;
    logic [PW-1:0]    sr_idx;
    logic [IDW-1:0]   sr_dst;
    logic [TAG_W-1:0] sr_tag;

    logic             msnp_fire;
    logic             mrsp_fire;

    snoop_bus_rr #(.N(NPORT), .IW(PW)) u_req_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (c_req_valid),
        .advance (rq_fire),
        .grant   (rq_grant),
        .any     (rq_any),
        .idx     (rq_idx)
    );

    snoop_bus_rr #(.N(NPORT), .IW(PW)) u_srsp_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (c_srsp_valid),
        .advance (sr_any),
        .grant   (sr_grant),
        .any     (sr_any),
        .idx     (sr_idx)
    );

    snoop_bus_block_timer #(.BLOCK_CYC(BLOCK_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .blocked (blocked)
    );

    always_comb begin
        // request / snoop channel: memory snoop wins over cache requests
        msnp_fire   = m_snp_valid && !blocked;
        m_snp_ready = !blocked;
        rq_fire     = rq_any && !blocked && !m_snp_valid;
        c_req_ready = rq_fire ? rq_grant : '0;

        // snoop replies are never held off by the busy interval
        c_srsp_ready = sr_grant;
        sr_dst       = c_srsp_dst[sr_idx*IDW +: IDW];
        sr_tag       = c_srsp_tag[sr_idx*TAG_W +: TAG_W];

        // a memory reply yields to a snoop reply aimed at the same port
        m_rsp_ready = !blocked && !(sr_any && (sr_dst == m_rsp_dst));
        mrsp_fire   = m_rsp_valid && m_rsp_ready;

        st_d        = st_q;
        st_d.req_v  = 1'b0;
        st_d.snp_v  = '0;
        st_d.rsp_v  = '0;
        st_d.hrsp_v = 1'b0;
        evt         = '0;

        if (msnp_fire) begin
            st_d.snp_v   = '1;
            st_d.snp_src = MEM_ID;
            st_d.snp_tag = m_snp_tag;
            evt.mem_snoop = 1'b1;
        end else if (rq_fire) begin
            st_d.req_v    = 1'b1;
            st_d.req_src  = IDW'(rq_idx);
            st_d.req_tag  = c_req_tag[rq_idx*TAG_W +: TAG_W];
            st_d.req_cach = c_req_cacheable[rq_idx];
            if (c_req_cacheable[rq_idx]) begin
                st_d.snp_v    = ~rq_grant;
                st_d.snp_src  = IDW'(rq_idx);
                st_d.snp_tag  = c_req_tag[rq_idx*TAG_W +: TAG_W];
                evt.req_snoop = (NPORT > 1);
            end
        end

        if (sr_any) begin
            if (sr_dst == MEM_ID) begin
                st_d.hrsp_v   = 1'b1;
                st_d.hrsp_tag = sr_tag;
                evt.home_reply = 1'b1;
            end else if (sr_dst < MEM_ID) begin
                st_d.rsp_v[sr_dst]               = 1'b1;
                st_d.rsp_peer[sr_dst]            = 1'b1;
                st_d.rsp_tag[sr_dst*TAG_W +: TAG_W] = sr_tag;
                evt.peer_reply = 1'b1;
            end
        end

        if (mrsp_fire && (m_rsp_dst < MEM_ID)) begin
            st_d.rsp_v[m_rsp_dst]               = 1'b1;
            st_d.rsp_peer[m_rsp_dst]            = 1'b0;
            st_d.rsp_tag[m_rsp_dst*TAG_W +: TAG_W] = m_rsp_tag;
            evt.mem_reply = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        m_req_valid     = st_q.req_v;
        m_req_src       = st_q.req_src;
        m_req_tag       = st_q.req_tag;
        m_req_cacheable = st_q.req_cach;
        // only ports that actually see the snoop can claim the answer
        m_req_inhibit   = st_q.req_v && st_q.req_cach && |(c_snp_inhibit & st_q.snp_v);
        c_snp_valid     = st_q.snp_v;
        c_snp_src       = st_q.snp_src;
        c_snp_tag       = st_q.snp_tag;
        c_rsp_valid     = st_q.rsp_v;
        c_rsp_tag       = st_q.rsp_tag;
        c_rsp_from_peer = st_q.rsp_peer;
        m_srsp_valid    = st_q.hrsp_v;
        m_srsp_tag      = st_q.hrsp_tag;
    end

endmodule

// File: rtl/snoop_bus_router_chk.sv
module snoop_bus_router_chk #(
    parameter int NPORT     = 3,
    parameter int IDW       = 2,
    parameter int BLOCK_CYC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] c_req_valid,
    input logic [NPORT-1:0] c_req_ready,
    input logic [NPORT-1:0] c_snp_valid,
    input logic [NPORT-1:0] c_srsp_valid,
    input logic [NPORT-1:0] c_srsp_ready,
    input logic             m_req_valid,
    input logic [IDW-1:0]   m_req_src,
    input logic             m_req_cacheable,
    input logic             m_req_inhibit,
    input logic             m_rsp_ready,
    input logic             m_snp_valid,
    input logic             m_snp_ready,
    input logic             m_srsp_valid
);

    a_r2_req_reaches_memory: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|(c_req_valid & c_req_ready)) |-> m_req_valid);

    a_r3_no_self_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && m_req_cacheable) |-> (((c_snp_valid >> m_req_src) & NPORT'(1)) == '0));

    a_r3_peers_snooped: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && m_req_cacheable) |-> ($countones(c_snp_valid) == NPORT - 1));

    a_r5_snoop_beats_request: assert property (@(posedge clk) disable iff (!rst_n)
        (m_snp_valid && m_snp_ready) |-> (c_req_ready == '0));

    a_r6_home_reply_source: assert property (@(posedge clk) disable iff (!rst_n)
        m_srsp_valid |-> $past(|(c_srsp_valid & c_srsp_ready)));

    a_r8_srsp_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (|c_srsp_valid) |-> (|c_srsp_ready));

    a_r9_inhibit_only_cached: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_inhibit |-> (m_req_valid && m_req_cacheable));

    a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_req_ready) && ((c_req_ready & ~c_req_valid) == '0));

    a_r11_single_srsp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_srsp_ready) && ((c_srsp_ready & ~c_srsp_valid) == '0));

    generate
        if (BLOCK_CYC > 0) begin : g_busy
            a_r7_busy_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
                $past(m_snp_valid && m_snp_ready) |-> (!m_snp_ready && !m_rsp_ready && c_req_ready == '0));
        end
    endgenerate

endmodule

bind snoop_bus_router snoop_bus_router_chk #(
    .NPORT     (NPORT),
    .IDW       (IDW),
    .BLOCK_CYC (BLOCK_CYC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .c_req_valid     (c_req_valid),
    .c_req_ready     (c_req_ready),
    .c_snp_valid     (c_snp_valid),
    .c_srsp_valid    (c_srsp_valid),
    .c_srsp_ready    (c_srsp_ready),
    .m_req_valid     (m_req_valid),
    .m_req_src       (m_req_src),
    .m_req_cacheable (m_req_cacheable),
    .m_req_inhibit   (m_req_inhibit),
    .m_rsp_ready     (m_rsp_ready),
    .m_snp_valid     (m_snp_valid),
    .m_snp_ready     (m_snp_ready),
    .m_srsp_valid    (m_srsp_valid)
);

// File: tb/snoop_bus_router_test.sv
module snoop_bus_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 3;
    localparam int TW  = 8;
    localparam int BLK = 3;
    localparam int IW  = 2;
    localparam int MEMID = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    c_req_valid, c_req_ready, c_req_cacheable;
    logic [N*TW-1:0] c_req_tag;
    logic [N-1:0]    c_snp_valid;
    logic [IW-1:0]   c_snp_src;
    logic [TW-1:0]   c_snp_tag;
    logic [N-1:0]    c_snp_inhibit;
    logic [N-1:0]    c_srsp_valid, c_srsp_ready;
    logic [N*IW-1:0] c_srsp_dst;
    logic [N*TW-1:0] c_srsp_tag;
    logic [N-1:0]    c_rsp_valid;
    logic [N*TW-1:0] c_rsp_tag;
    logic [N-1:0]    c_rsp_from_peer;
    logic            m_req_valid;
    logic [IW-1:0]   m_req_src;
    logic [TW-1:0]   m_req_tag;
    logic            m_req_cacheable, m_req_inhibit;
    logic            m_rsp_valid, m_rsp_ready;
    logic [IW-1:0]   m_rsp_dst;
    logic [TW-1:0]   m_rsp_tag;
    logic            m_snp_valid, m_snp_ready;
    logic [TW-1:0]   m_snp_tag;
    logic            m_srsp_valid;
    logic [TW-1:0]   m_srsp_tag;

    snoop_bus_router #(.NPORT(N), .TAG_W(TW), .BLOCK_CYC(BLK)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // reference model state
    int          blk, pr, ps;
    logic        e_req_v, e_req_cach, e_srsp_v;
    logic [1:0]  e_req_src, e_snp_src;
    logic [7:0]  e_req_tag, e_snp_tag, e_srsp_tag;
    logic [2:0]  e_snp_v, e_rsp_v, e_peer;
    logic [7:0]  e_rsp_tag [N];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int rr_pick(input logic [N-1:0] v, input int p);
        for (int k = 0; k < N; k++) begin
            int j;
            j = (p + k) % N;
            if (v[j]) return j;
        end
        return -1;
    endfunction

    task automatic model_reset();
        blk = 0; pr = 0; ps = 0;
        e_req_v = 0; e_req_cach = 0; e_srsp_v = 0;
        e_req_src = 0; e_snp_src = 0; e_req_tag = 0; e_snp_tag = 0; e_srsp_tag = 0;
        e_snp_v = 0; e_rsp_v = 0; e_peer = 0;
        for (int i = 0; i < N; i++) e_rsp_tag[i] = 0;
    endtask

    task automatic idle_inputs();
        c_req_valid = 0; c_req_cacheable = 0; c_req_tag = 0;
        c_snp_inhibit = 0; c_srsp_valid = 0; c_srsp_dst = 0; c_srsp_tag = 0;
        m_rsp_valid = 0; m_rsp_dst = 0; m_rsp_tag = 0; m_snp_valid = 0; m_snp_tag = 0;
    endtask

    // Compare one cycle, advance the model across the next rising edge.
    task automatic step();
        bit         busy;
        int         g, sg, sdst;
        logic [2:0] x_req_rdy, x_srsp_rdy;
        logic       x_mrsp_rdy, x_inh;
        logic       n_req_v, n_req_cach, n_srsp_v, ev;
        logic [1:0] n_req_src, n_snp_src;
        logic [7:0] n_req_tag, n_snp_tag, n_srsp_tag;
        logic [2:0] n_snp_v, n_rsp_v, n_peer;
        logic [7:0] n_rsp_tag [N];
        #1;
        busy = (blk != 0);
        g    = rr_pick(c_req_valid, pr);
        sg   = rr_pick(c_srsp_valid, ps);
        sdst = (sg >= 0) ? int'(c_srsp_dst[sg*IW +: IW]) : -1;
        x_req_rdy  = (!busy && !m_snp_valid && g >= 0) ? 3'(1 << g) : 3'b0;
        x_srsp_rdy = (sg >= 0) ? 3'(1 << sg) : 3'b0;
        x_mrsp_rdy = !busy && !(sg >= 0 && sdst == int'(m_rsp_dst));
        x_inh      = e_req_v && e_req_cach && |(c_snp_inhibit & e_snp_v);

        chk("R10", "c_req_ready", c_req_ready, x_req_rdy);
        chk("R7",  "m_snp_ready", m_snp_ready, !busy);
        chk("R12", "m_rsp_ready", m_rsp_ready, x_mrsp_rdy);
        chk("R11", "c_srsp_ready", c_srsp_ready, x_srsp_rdy);
        if (busy && sg >= 0) chk("R8", "srsp accepted while busy", |c_srsp_ready, 1'b1);
        chk("R9", "m_req_inhibit", m_req_inhibit, x_inh);
        chk("R2", "m_req_valid", m_req_valid, e_req_v);
        if (e_req_v) begin
            chk("R2", "m_req_src", m_req_src, e_req_src);
            chk("R2", "m_req_tag", m_req_tag, e_req_tag);
            chk("R2", "m_req_cacheable", m_req_cacheable, e_req_cach);
        end
        chk("R3", "c_snp_valid", c_snp_valid, e_snp_v);
        if (e_snp_v != 0) begin
            chk("R5", "c_snp_src", c_snp_src, e_snp_src);
            chk("R3", "c_snp_tag", c_snp_tag, e_snp_tag);
        end
        chk("R4", "c_rsp_valid", c_rsp_valid, e_rsp_v);
        for (int i = 0; i < N; i++) begin
            if (e_rsp_v[i]) begin
                chk("R4", "c_rsp_tag", c_rsp_tag[i*TW +: TW], e_rsp_tag[i]);
                chk("R6", "c_rsp_from_peer", c_rsp_from_peer[i], e_peer[i]);
            end
        end
        chk("R6", "m_srsp_valid", m_srsp_valid, e_srsp_v);
        if (e_srsp_v) chk("R6", "m_srsp_tag", m_srsp_tag, e_srsp_tag);

        n_req_v = 0; n_req_cach = e_req_cach; n_req_src = e_req_src; n_req_tag = e_req_tag;
        n_snp_v = 0; n_snp_src = e_snp_src; n_snp_tag = e_snp_tag;
        n_rsp_v = 0; n_peer = e_peer; n_srsp_v = 0; n_srsp_tag = e_srsp_tag;
        for (int i = 0; i < N; i++) n_rsp_tag[i] = e_rsp_tag[i];
        ev = 0;
        if (m_snp_valid && !busy) begin
            n_snp_v = 3'b111; n_snp_src = 2'(MEMID); n_snp_tag = m_snp_tag; ev = 1;
        end else if (x_req_rdy != 0) begin
            n_req_v = 1; n_req_src = 2'(g); n_req_tag = c_req_tag[g*TW +: TW];
            n_req_cach = c_req_cacheable[g];
            if (c_req_cacheable[g]) begin
                n_snp_v = ~3'(1 << g); n_snp_src = 2'(g); n_snp_tag = c_req_tag[g*TW +: TW]; ev = 1;
            end
            pr = (g + 1) % N;
        end
        if (sg >= 0) begin
            ps = (sg + 1) % N;
            if (sdst == MEMID) begin
                n_srsp_v = 1; n_srsp_tag = c_srsp_tag[sg*TW +: TW]; ev = 1;
            end else begin
                n_rsp_v[sdst] = 1; n_peer[sdst] = 1; n_rsp_tag[sdst] = c_srsp_tag[sg*TW +: TW]; ev = 1;
            end
        end
        if (m_rsp_valid && x_mrsp_rdy) begin
            n_rsp_v[m_rsp_dst] = 1; n_peer[m_rsp_dst] = 0; n_rsp_tag[m_rsp_dst] = m_rsp_tag; ev = 1;
        end
        @(posedge clk);
        blk = ev ? BLK : ((blk != 0) ? blk - 1 : 0);
        e_req_v = n_req_v; e_req_cach = n_req_cach; e_req_src = n_req_src; e_req_tag = n_req_tag;
        e_snp_v = n_snp_v; e_snp_src = n_snp_src; e_snp_tag = n_snp_tag;
        e_rsp_v = n_rsp_v; e_peer = n_peer; e_srsp_v = n_srsp_v; e_srsp_tag = n_srsp_tag;
        for (int i = 0; i < N; i++) e_rsp_tag[i] = n_rsp_tag[i];
        @(negedge clk);
    endtask

    task automatic rand_inputs();
        c_req_valid     = 3'($urandom) & 3'($urandom);
        c_req_cacheable = 3'($urandom);
        c_req_tag       = 24'($urandom);
        c_snp_inhibit   = 3'($urandom);
        c_srsp_valid    = 3'($urandom) & 3'($urandom) & 3'($urandom);
        for (int i = 0; i < N; i++) c_srsp_dst[i*IW +: IW] = 2'($urandom % 4);
        c_srsp_tag      = 24'($urandom);
        m_rsp_valid     = ($urandom % 3) == 0;
        m_rsp_dst       = 2'($urandom % 3);
        m_rsp_tag       = 8'($urandom);
        m_snp_valid     = ($urandom % 5) == 0;
        m_snp_tag       = 8'($urandom);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        idle_inputs();
        model_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: clean state right after reset
        chk("R1", "valids after reset",
            {c_snp_valid, c_rsp_valid, m_req_valid, m_srsp_valid}, '0);
        chk("R1", "readies after reset", {m_snp_ready, m_rsp_ready}, 2'b11);
        step();

        // R7: uncacheable request from port 1 starts no busy interval
        c_req_valid = 3'b010; c_req_tag[1*TW +: TW] = 8'h11;
        step();
        idle_inputs(); c_req_valid = 3'b001;
        step();
        chk("R7", "no busy after uncached", m_snp_ready, 1'b1);
        idle_inputs();
        step();

        // R9: cacheable request from port 0, inhibit from requester and peer 1
        c_req_valid = 3'b001; c_req_cacheable = 3'b001; c_req_tag[0 +: TW] = 8'h22;
        step();
        idle_inputs(); c_snp_inhibit = 3'b011;
        step();
        idle_inputs();
        repeat (3) step();
        // R9: inhibit only from requester (port 2) is ignored
        c_req_valid = 3'b100; c_req_cacheable = 3'b100; c_req_tag[2*TW +: TW] = 8'h33;
        step();
        idle_inputs(); c_snp_inhibit = 3'b100;
        step();
        idle_inputs();
        repeat (3) step();

        // R5/R7: memory snoop collides with a request, request held off while busy
        m_snp_valid = 1; m_snp_tag = 8'h44; c_req_valid = 3'b010; c_req_cacheable = 3'b010;
        step();
        m_snp_valid = 0;
        repeat (4) step();
        idle_inputs();

        // R12: memory reply and snoop reply both aimed at port 0
        c_srsp_valid = 3'b100; c_srsp_dst[2*IW +: IW] = 2'd0; c_srsp_tag[2*TW +: TW] = 8'h55;
        m_rsp_valid = 1; m_rsp_dst = 0; m_rsp_tag = 8'h66;
        step();
        // R6/R8: snoop reply to memory during the busy interval
        c_srsp_valid = 3'b001; c_srsp_dst[0 +: IW] = 2'(MEMID); c_srsp_tag[0 +: TW] = 8'h77;
        step();
        idle_inputs();
        repeat (4) step();

        for (int n = 0; n < 4000; n++) begin
            rand_inputs();
            step();
        end
        idle_inputs();
        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule